// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This block picks the smaller or the larger of two single-precision (binary32) operands. A per-operation policy input sets how NaN inputs are treated. One datapath serves all three policies: operand classification, a sign-magnitude comparator, and a selection stage.

- **Legacy ordered-select policy:** min behaves as `a < b ? a : b` and max as `a > b ? a : b`. Because any comparison with a NaN is false, the second operand wins whenever a NaN is present or the operands compare equal.
- **Number-preferring policy:** a quiet NaN loses against a number.
- **NaN-propagating policy:** any NaN forces the canonical quiet NaN.

An invalid flag reports signalling NaN inputs in every policy. A parameter places an optional output register with a valid bit after the logic. With the register present, a result appears one cycle after its operands are accepted.

Top module: `fpmm_unit`

## Requirements
- R1: An operand is NaN when its 8-bit exponent field (bits 30:23) is all ones and its 23-bit fraction (bits 22:0) is nonzero; it is signalling when fraction bit 22 is 0 and quiet when that bit is 1; infinities are ordinary numbers.
- R2: `invalid` is 1 exactly when at least one operand is a signalling NaN, under every policy.
- R3: When neither operand is NaN and the operands are not two zeros of opposite sign, every policy returns the numeric minimum (`sel_max`=0) or maximum (`sel_max`=1), ordering by sign and then magnitude.
- R4: Under the legacy policy (`policy`=0), the result is `op_b` whenever either operand is NaN, quiet or signalling.
- R5: Under the legacy policy, when the operands compare equal, including +0 against -0, the result is `op_b`.
- R6: Under the number-preferring policy (`policy`=1), when exactly one operand is a quiet NaN and neither is signalling, the result is the other operand, whichever input holds the NaN.
- R7: Under the number-preferring policy, when both operands are NaN or either is signalling, the result is 0x7FC00000.
- R8: Under the propagating policy (`policy`=2, with 3 treated alike), any NaN operand gives 0x7FC00000.
- R9: Under policies 1 to 3, -0 orders below +0: min of the pair returns 0x80000000 and max returns 0x00000000.
- R10: With `REG_OUT`=1, `out_valid`, `result` and `invalid` follow an accepted input one clock later; with `REG_OUT`=0 they follow it combinationally.
- R11: With `REG_OUT`=1, synchronous reset clears `out_valid`, `result` and `invalid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 32 | First operand (binary32) |
| op_b | input | 32 | Second operand (binary32) |
| sel_max | input | 1 | 0 selects minimum, 1 selects maximum |
| policy | input | 2 | NaN policy: 0 legacy, 1 number-preferring, 2/3 propagating |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Selected value |
| invalid | output | 1 | A signalling NaN was seen |

## Verification
The bench builds two copies side by side, both with the default 8-bit exponent and 23-bit fraction.

- One copy has `REG_OUT`=1. It exposes the reset values, the one-cycle delay of result and flag, and the drop of `out_valid` once inputs stop.
- The other copy has `REG_OUT`=0. Its result is checked in the same cycle the operands are driven.

Both copies are compared with a model that orders operands by a monotone integer key rather than by sign-magnitude logic. Random operands are biased toward zeros, infinities, quiet and signalling NaNs and equal pairs, so every policy branch is reached on both variants.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

  typedef enum logic [1:0] {
    POL_LEGACY   = 2'd0,
    POL_NUMBER   = 2'd1,
    POL_PROP     = 2'd2,
    POL_PROP_ALT = 2'd3
  } nan_policy_t;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } op_class_t;

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op,
  output op_class_t    cls
);

  logic exp_ones;
  logic frac_nz;

  always_comb begin
    exp_ones    = &op[W-2:FRAC_W];
    frac_nz     = |op[FRAC_W-1:0];
    cls.is_nan  = exp_ones && frac_nz;
    cls.is_snan = exp_ones && frac_nz && !op[FRAC_W-1];
  end

  // R1: a signalling operand is always a NaN with its fraction MSB clear
  always_comb begin
    if (cls.is_snan) begin
      assert_snan_form_R1: assert (cls.is_nan && !op[FRAC_W-1]);
    end
  end

endmodule

// File: rtl/fpmm_compare.sv
module fpmm_compare #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_lt_b,
  output logic         b_lt_a,
  output logic         both_zero
);

  logic [W-2:0] mag_a;
  logic [W-2:0] mag_b;
  logic         mag_lt;
  logic         mag_gt;

  always_comb begin
    mag_a     = a[W-2:0];
    mag_b     = b[W-2:0];
    mag_lt    = mag_a < mag_b;
    mag_gt    = mag_a > mag_b;
    both_zero = (mag_a == '0) && (mag_b == '0);
    if (a[W-1] != b[W-1]) begin
      a_lt_b = a[W-1];
      b_lt_a = b[W-1];
    end else if (!a[W-1]) begin
      a_lt_b = mag_lt;
      b_lt_a = mag_gt;
    end else begin
      a_lt_b = mag_gt;
      b_lt_a = mag_lt;
    end
  end

  // R3: strict ordering never claims both directions at once
  always_comb begin
    assert_order_R3: assert (!(a_lt_b && b_lt_a));
  end

endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
  import fpmm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  op_class_t    cls_a,
  input  op_class_t    cls_b,
  input  logic         a_lt_b,
  input  logic         b_lt_a,
  input  logic         both_zero,
  input  logic         sel_max,
  input  nan_policy_t  policy,
  output logic [W-1:0] res,
  output logic         invalid
);

  localparam logic [W-1:0] CANON_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0] legacy_num;
  logic [W-1:0] ordered_num;
  logic         any_nan;
  logic         any_snan;

  always_comb begin
    any_nan  = cls_a.is_nan || cls_b.is_nan;
    any_snan = cls_a.is_snan || cls_b.is_snan;
    invalid  = any_snan;

    if (sel_max) legacy_num = (b_lt_a && !both_zero) ? a : b;
    else         legacy_num = (a_lt_b && !both_zero) ? a : b;

    if (sel_max) ordered_num = a_lt_b ? b : a;
    else         ordered_num = b_lt_a ? b : a;

    unique case (policy)
      POL_LEGACY: res = any_nan ? b : legacy_num;
      POL_NUMBER: begin
        if (any_snan || (cls_a.is_nan && cls_b.is_nan)) res = CANON_QNAN;
        else if (cls_a.is_nan)                          res = b;
        else if (cls_b.is_nan)                          res = a;
        else                                            res = ordered_num;
      end
      default: res = any_nan ? CANON_QNAN : ordered_num;
    endcase
  end

  always_comb begin
    if (policy == POL_LEGACY && any_nan) begin
      assert_legacy_nan_R4: assert (res == b);
    end
    if (policy == POL_NUMBER && !any_snan && (cls_a.is_nan != cls_b.is_nan)) begin
      assert_number_wins_R6: assert (res == (cls_a.is_nan ? b : a));
    end
    if ((policy == POL_PROP || policy == POL_PROP_ALT) && any_nan) begin
      assert_propagate_R8: assert (res == CANON_QNAN);
    end
    if (!any_nan) begin
      assert_pick_operand_R3: assert (res == a || res == b);
    end
  end

endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
  import fpmm_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sel_max,
  input  logic [1:0]   policy,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         invalid
);

  op_class_t    cls_a;
  op_class_t    cls_b;
  logic         a_lt_b;
  logic         b_lt_a;
  logic         both_zero;
  logic [W-1:0] res_c;
  logic         inv_c;
  nan_policy_t  pol;

  assign pol = nan_policy_t'(policy);

  fpmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (.op(op_a), .cls(cls_a));
  fpmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (.op(op_b), .cls(cls_b));

  fpmm_compare #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cmp (
    .a(op_a), .b(op_b),
    .a_lt_b(a_lt_b), .b_lt_a(b_lt_a), .both_zero(both_zero)
  );

  fpmm_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
    .a(op_a), .b(op_b), .cls_a(cls_a), .cls_b(cls_b),
    .a_lt_b(a_lt_b), .b_lt_a(b_lt_a), .both_zero(both_zero),
    .sel_max(sel_max), .policy(pol),
    .res(res_c), .invalid(inv_c)
  );

  // R2: the flag follows the signalling status of the classifiers
  always_comb begin
    assert_flag_R2: assert (inv_c == (cls_a.is_snan || cls_b.is_snan));
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          result    <= '0;
          invalid   <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            result  <= res_c;
            invalid <= inv_c;
          end
        end
      end

      assert_valid_lat_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      assert_idle_lat_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      assert_data_lat_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (result == $past(res_c) && invalid == $past(inv_c)));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = res_c;
      assign invalid   = inv_c;
    end
  endgenerate

endmodule

// File: tb/test_fpmm_unit.sv
module test_fpmm_unit;

  localparam logic [31:0] QCAN = 32'h7FC0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        sel_max = 1'b0;
  logic [1:0]  policy = 2'd0;
  logic        r_valid, c_valid, r_inv, c_inv;
  logic [31:0] r_res, c_res;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fpmm_unit #(.REG_OUT(1'b1)) i_fpmm_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sel_max(sel_max), .policy(policy),
    .out_valid(r_valid), .result(r_res), .invalid(r_inv)
  );

  fpmm_unit #(.REG_OUT(1'b0)) i_fpmm_unit_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sel_max(sel_max), .policy(policy),
    .out_valid(c_valid), .result(c_res), .invalid(c_inv)
  );

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  function automatic bit is_snan(logic [31:0] x);
    return is_nan(x) && (x[22] == 1'b0);
  endfunction

  function automatic logic [31:0] okey(logic [31:0] x);
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  function automatic logic [31:0] ref_res(logic [31:0] a, logic [31:0] b, bit mx, logic [1:0] pol);
    bit na = is_nan(a);
    bit nb = is_nan(b);
    bit sn = is_snan(a) || is_snan(b);
    bit zz = (a[30:0] == 31'd0) && (b[30:0] == 31'd0);
    if (pol == 2'd0) begin
      if (na || nb || zz) return b;
      if (mx) return (okey(a) > okey(b)) ? a : b;
      return (okey(a) < okey(b)) ? a : b;
    end
    if (pol == 2'd1) begin
      if (sn || (na && nb)) return QCAN;
      if (na) return b;
      if (nb) return a;
    end else if (na || nb) return QCAN;
    if (mx) return (okey(a) >= okey(b)) ? a : b;
    return (okey(a) <= okey(b)) ? a : b;
  endfunction

  function automatic string tag_of(logic [31:0] a, logic [31:0] b, logic [1:0] pol);
    bit anyn = is_nan(a) || is_nan(b);
    if (pol == 2'd0 && anyn) return "R4";
    if (pol == 2'd0 && okey(a) == okey(b)) return "R5";
    if (pol == 2'd0 && a[30:0] == 31'd0 && b[30:0] == 31'd0) return "R5";
    if (pol == 2'd1 && anyn && !is_snan(a) && !is_snan(b) && (is_nan(a) != is_nan(b))) return "R6";
    if (pol == 2'd1 && anyn) return "R7";
    if (anyn) return "R8";
    if (a[30:0] == 31'd0 && b[30:0] == 31'd0 && a[31] != b[31]) return "R9";
    return "R3";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // drives at a falling edge, checks the combinational copy, then the registered copy
  task automatic apply(logic [31:0] a, logic [31:0] b, bit mx, logic [1:0] pol);
    logic [31:0] er = ref_res(a, b, mx, pol);
    logic [31:0] ei = {31'd0, is_snan(a) || is_snan(b)};
    string t = tag_of(a, b, pol);
    op_a = a; op_b = b; sel_max = mx; policy = pol; in_valid = 1'b1;
    #1;
    chk(t, "comb result", c_res, er);
    chk("R2", "comb invalid", {31'd0, c_inv}, ei);
    @(negedge clk);
    chk(t, "reg result", r_res, er);
    chk("R2", "reg invalid", {31'd0, r_inv}, ei);
    chk("R10", "reg valid", {31'd0, r_valid}, 32'd1);
  endtask

  function automatic logic [31:0] pick(logic [31:0] other);
    int unsigned k = $urandom_range(0, 11);
    logic [31:0] r = $urandom;
    case (k)
      0: return {r[31], 31'd0};
      1: return {r[31], 8'hFF, 23'd0};
      2: return {r[31], 8'hFF, 1'b1, r[21:0]};
      3: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      4: return other;
      5: return {~other[31], other[30:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R11", "reset valid", {31'd0, r_valid}, 32'd0);
    chk("R11", "reset result", r_res, 32'd0);
    chk("R11", "reset invalid", {31'd0, r_inv}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1: infinity is a number, not a NaN
    apply(32'h7F80_0000, 32'h3F80_0000, 1'b1, 2'd2);
    chk("R1", "inf is numeric", c_res, 32'h7F80_0000);
    // R1: fraction MSB 1 is quiet, MSB 0 is signalling
    apply(32'h7FC0_0001, 32'h3F80_0000, 1'b0, 2'd1);
    chk("R1", "quiet nan loses", c_res, 32'h3F80_0000);
    apply(32'h7F80_0001, 32'h3F80_0000, 1'b0, 2'd1);
    chk("R1", "snan flags", {31'd0, c_inv}, 32'd1);
    // R4: legacy returns second operand when NaN appears in either place
    apply(32'h3F80_0000, 32'h7FC0_0000, 1'b0, 2'd0);
    apply(32'h7FC0_0000, 32'h3F80_0000, 1'b0, 2'd0);
    apply(32'h3F80_0000, 32'hFF80_0005, 1'b1, 2'd0);
    // R5: signed zeros are equal in legacy mode
    apply(32'h8000_0000, 32'h0000_0000, 1'b0, 2'd0);
    apply(32'h0000_0000, 32'h8000_0000, 1'b1, 2'd0);
    // R6: number wins over quiet NaN in either position
    apply(32'h7FC0_0000, 32'hC000_0000, 1'b1, 2'd1);
    apply(32'hC000_0000, 32'hFFC1_2345, 1'b0, 2'd1);
    // R7: both NaN, or signalling, give canonical NaN
    apply(32'h7FC0_0000, 32'hFFC0_0000, 1'b0, 2'd1);
    apply(32'h7F80_0001, 32'h4000_0000, 1'b1, 2'd1);
    // R8: propagation under codes 2 and 3
    apply(32'h4000_0000, 32'h7FC0_0000, 1'b0, 2'd2);
    apply(32'h7FC0_0000, 32'h4000_0000, 1'b1, 2'd3);
    // R9: -0 below +0
    apply(32'h0000_0000, 32'h8000_0000, 1'b0, 2'd1);
    apply(32'h8000_0000, 32'h0000_0000, 1'b1, 2'd2);
    // R3: ordinary numbers including negatives and infinities
    apply(32'hBF80_0000, 32'h3F80_0000, 1'b0, 2'd0);
    apply(32'hC000_0000, 32'hBF80_0000, 1'b1, 2'd1);
    apply(32'hFF80_0000, 32'h7F80_0000, 1'b0, 2'd3);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = pick(a);
      a = pick(b);
      apply(a, b, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
    end

    // R10: out_valid drops one cycle after input stops
    in_valid = 1'b0;
    #1;
    chk("R10", "comb valid idle", {31'd0, c_valid}, 32'd0);
    @(negedge clk);
    chk("R10", "reg valid idle", {31'd0, r_valid}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule